// File: doc/BRIEF.md
# Dual-Bank Serial Buffer RAM

This block is the buffer store that sits between a processor bus and the transfer engine of a buffered serial peripheral. It keeps two banks of 32-bit words. The transmit bank holds outgoing data with a control half. The receive bank holds incoming data with a status half. Every stored word carries four parity bits, which the block computes itself. A parity bit is updated whenever the byte it covers is written.

The bus side uses word-granular addressing with byte-lane enables, so it supports 8-, 16- and 32-bit accesses. The top bit of the word address selects the bank. The transmit window accepts reads and writes. The receive window is read-only: bus writes there are dropped. The seven buffer-number bits are folded modulo the implemented depth, so buffer numbers beyond the depth alias onto real entries.

The engine side reads transmit words by buffer index. It writes received words back by buffer index, and supplies only the data half and the upper status byte. The block fills in the chip-select byte itself, copying it from the matching transmit entry's control half.

Top module: `sbuf_dualbank_ram`

## Requirements
- R1: After reset, `bus_rdata`, `bus_rpar`, `eng_tx_word` and `eng_tx_par` are zero, and every entry of both banks reads as zero.
- R2: A bus access with `bus_word_addr[7]`=0 targets the transmit bank. A read there presents the stored word on `bus_rdata` at the first rising edge after the cycle in which `bus_sel`=1 and `bus_wr`=0 are sampled.
- R3: A transmit-bank write changes only the byte lanes whose `bus_be` bit is set. Lane i is bits 8i+7:8i, so 8-, 16- and 32-bit writes are expressed as 1-, 2- and 4-lane masks.
- R4: Parity is even per byte. Returned parity bit i (`bus_rpar`, `eng_tx_par`) equals the XOR of byte i of the returned word. The parity of a lane is recomputed only when that lane is written.
- R5: A bus access with `bus_word_addr[7]`=1 reads the receive bank. A bus write there changes no entry in either bank.
- R6: The buffer number `bus_word_addr[6:0]` selects entry (number mod DEPTH). A write to buffer DEPTH+k lands on entry k, and reads of aliased numbers return entry k. This holds for both banks.
- R7: `eng_tx_word`/`eng_tx_par` show the transmit entry at `eng_tx_idx` one rising edge later. A bus write to that same entry in the same cycle is already included.
- R8: When `eng_rx_we`=1, receive entry `eng_rx_idx` becomes {`eng_rx_flags`, cs, `eng_rx_data`}. Here cs is bits 23:16 of transmit entry `eng_rx_idx`, including a bus write to that transmit entry in the same cycle.
- R9: A bus read of a receive entry in the same cycle as an engine write to that entry returns the entry's previous contents. The new contents are visible from the next read onward.
- R10: `bus_rdata` and `bus_rpar` change only after a bus read. Idle cycles and bus writes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 8 | Byte offset bits 9:2; bit 7 selects the bank, bits 6:0 the buffer number |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rpar | output | 4 | Stored parity of the read word |
| eng_tx_idx | input | $clog2(DEPTH) | Engine transmit read index |
| eng_tx_word | output | 32 | Registered transmit word at `eng_tx_idx` |
| eng_tx_par | output | 4 | Parity of `eng_tx_word` |
| eng_rx_we | input | 1 | Engine receive write strobe |
| eng_rx_idx | input | $clog2(DEPTH) | Engine receive write index |
| eng_rx_data | input | 16 | Received data half |
| eng_rx_flags | input | 8 | Status bits 31:24 |

## Verification
The bench builds the block with DEPTH=16, not the default 32. With that depth, buffer numbers 16 to 127 all fold onto real entries. The largest transmit buffer number (127 → 15) and receive aliases become reachable with a handful of accesses, and the index wrap is checked at a non-default power of two. The same depth keeps the same-entry collisions cheap to arrange: a bus write against an engine read, a bus write against the chip-select copy, and an engine write against a bus read.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    localparam int WORD_W   = 32;
    localparam int LANES    = WORD_W / 8;
    localparam int WADDR_W  = 8;
    localparam int BUFNUM_W = WADDR_W - 1;
    localparam int HALF_W   = WORD_W / 2;
    localparam int CS_LSB   = 16;
    localparam int CS_W     = 8;
    localparam int FLAG_W   = WORD_W - CS_LSB - CS_W;

    typedef enum logic [0:0] {
        WIN_TX = 1'b0,
        WIN_RX = 1'b1
    } win_e;

    typedef struct packed {
        logic [LANES-1:0]  par;
        logic [WORD_W-1:0] data;
    } pword_t;

    function automatic logic [LANES-1:0] byte_parity(logic [WORD_W-1:0] w);
        logic [LANES-1:0] p;
        for (int i = 0; i < LANES; i++) begin
            p[i] = ^w[8*i +: 8];
        end
        return p;
    endfunction

    function automatic pword_t merge_lanes(pword_t old, logic [WORD_W-1:0] wd,
                                           logic [LANES-1:0] be);
        pword_t res;
        logic [LANES-1:0] p;
        res = old;
        p   = byte_parity(wd);
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) begin
                res.data[8*i +: 8] = wd[8*i +: 8];
                res.par[i]         = p[i];
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sbuf_addr_decode.sv
module sbuf_addr_decode
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [WADDR_W-1:0] word_addr,
    output win_e               win,
    output logic [IDXW-1:0]    idx
);

    logic [BUFNUM_W-1:0] buf_num;
    logic [31:0]         folded;

    assign buf_num = word_addr[BUFNUM_W-1:0];
    assign win     = word_addr[WADDR_W-1] ? WIN_RX : WIN_TX;

    // buffer numbers past the implemented depth fold back onto real entries
    assign folded  = {{(32-BUFNUM_W){1'b0}}, buf_num} % 32'(DEPTH);
    assign idx     = folded[IDXW-1:0];

endmodule

// File: rtl/sbuf_bank.sv
module sbuf_bank
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NRD   = 1,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDXW-1:0]           waddr,
    input  logic [LANES-1:0]          wbe,
    input  logic [WORD_W-1:0]         wdata,
    input  logic [NRD-1:0][IDXW-1:0]  rd_addr,
    output pword_t [NRD-1:0]          rd_word
);

    pword_t mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= merge_lanes(mem[waddr], wdata, wbe);
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_word[g] = mem[rd_addr[g]];
    end

    // R5: with no write on the previous edge, a steady read address sees a steady word
    a_r5_idle_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_addr[0]) && !$past(we)) |-> $stable(rd_word[0]));

endmodule

// File: rtl/sbuf_dualbank_ram.sv
module sbuf_dualbank_ram
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_word_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [3:0]         bus_rpar,
    input  logic [IDXW-1:0]    eng_tx_idx,
    output logic [31:0]        eng_tx_word,
    output logic [3:0]         eng_tx_par,
    input  logic               eng_rx_we,
    input  logic [IDXW-1:0]    eng_rx_idx,
    input  logic [15:0]        eng_rx_data,
    input  logic [7:0]         eng_rx_flags
);

    win_e                   bus_win;
    logic [IDXW-1:0]        bus_idx;
    logic                   tx_we;
    logic                   bus_rd;
    logic [2:0][IDXW-1:0]   tx_rd_addr;
    pword_t [2:0]           tx_rd;
    logic [0:0][IDXW-1:0]   rx_rd_addr;
    pword_t [0:0]           rx_rd;
    pword_t                 tx_fwd_eng;
    pword_t                 tx_fwd_cs;
    logic [WORD_W-1:0]      rx_word;
    pword_t                 bus_pick;
    pword_t                 bus_q;
    pword_t                 eng_q;

    sbuf_addr_decode #(.DEPTH(DEPTH)) u_dec (
        .word_addr (bus_word_addr),
        .win       (bus_win),
        .idx       (bus_idx)
    );

    assign tx_we  = bus_sel && bus_wr && (bus_win == WIN_TX);
    assign bus_rd = bus_sel && !bus_wr;

    // port 0: bus, port 1: engine transmit read, port 2: chip-select copy
    assign tx_rd_addr = {eng_rx_idx, eng_tx_idx, bus_idx};

    sbuf_bank #(.DEPTH(DEPTH), .NRD(3)) u_tx_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tx_we),
        .waddr   (bus_idx),
        .wbe     (bus_be),
        .wdata   (bus_wdata),
        .rd_addr (tx_rd_addr),
        .rd_word (tx_rd)
    );

    // same-cycle bus write is applied before any engine-side use of the entry
    always_comb begin
        tx_fwd_eng = tx_rd[1];
        tx_fwd_cs  = tx_rd[2];
        if (tx_we && (bus_idx == eng_tx_idx)) begin
            tx_fwd_eng = merge_lanes(tx_rd[1], bus_wdata, bus_be);
        end
        if (tx_we && (bus_idx == eng_rx_idx)) begin
            tx_fwd_cs = merge_lanes(tx_rd[2], bus_wdata, bus_be);
        end
    end

    assign rx_word    = {eng_rx_flags, tx_fwd_cs.data[CS_LSB +: CS_W], eng_rx_data};
    assign rx_rd_addr = bus_idx;

    sbuf_bank #(.DEPTH(DEPTH), .NRD(1)) u_rx_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (eng_rx_we),
        .waddr   (eng_rx_idx),
        .wbe     ({LANES{1'b1}}),
        .wdata   (rx_word),
        .rd_addr (rx_rd_addr),
        .rd_word (rx_rd)
    );

    always_comb begin
        unique case (bus_win)
            WIN_TX: bus_pick = tx_rd[0];
            WIN_RX: bus_pick = rx_rd[0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
            eng_q <= '0;
        end else begin
            if (bus_rd) begin
                bus_q <= bus_pick;
            end
            eng_q <= tx_fwd_eng;
        end
    end

    assign bus_rdata   = bus_q.data;
    assign bus_rpar    = bus_q.par;
    assign eng_tx_word = eng_q.data;
    assign eng_tx_par  = eng_q.par;

    // R4: stored parity travels with the word and matches it
    a_r4_bus_parity: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rpar == byte_parity(bus_rdata));

    a_r4_eng_parity: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_par == byte_parity(eng_tx_word));

    // R10: read data moves only after a bus read
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && !bus_wr) |-> ($stable(bus_rdata) && $stable(bus_rpar)));

endmodule

// File: tb/sim_sbuf_dualbank_ram.sv
module sim_sbuf_dualbank_ram;

    localparam int DEPTH = 16;
    localparam int IDXW  = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bus_sel, bus_wr;
    logic [7:0]      bus_word_addr;
    logic [3:0]      bus_be;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [3:0]      bus_rpar;
    logic [IDXW-1:0] eng_tx_idx;
    logic [31:0]     eng_tx_word;
    logic [3:0]      eng_tx_par;
    logic            eng_rx_we;
    logic [IDXW-1:0] eng_rx_idx;
    logic [15:0]     eng_rx_data;
    logic [7:0]      eng_rx_flags;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] tx_m [DEPTH];
    logic [31:0] rx_m [DEPTH];

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        issued;

    always #4 clk = ~clk;

    sbuf_dualbank_ram #(.DEPTH(DEPTH)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_word_addr (bus_word_addr),
        .bus_be        (bus_be),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_rpar      (bus_rpar),
        .eng_tx_idx    (eng_tx_idx),
        .eng_tx_word   (eng_tx_word),
        .eng_tx_par    (eng_tx_par),
        .eng_rx_we     (eng_rx_we),
        .eng_rx_idx    (eng_rx_idx),
        .eng_rx_data   (eng_rx_data),
        .eng_rx_flags  (eng_rx_flags)
    );

    function automatic logic [3:0] par4(logic [31:0] w);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^w[8*i +: 8];
        return p;
    endfunction

    function automatic int fold(logic [7:0] a);
        return int'(a[6:0]) % DEPTH;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic model_tx_write(logic [7:0] a, logic [3:0] be, logic [31:0] d);
        if (!a[7]) begin
            for (int i = 0; i < 4; i++)
                if (be[i]) tx_m[fold(a)][8*i +: 8] = d[8*i +: 8];
        end
    endtask

    // all driver tasks start and end on a falling edge
    task automatic bus_write(logic [7:0] a, logic [3:0] be, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word_addr = a; bus_be = be; bus_wdata = d;
        model_tx_write(a, be, d);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic push_read(logic [7:0] a, string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_word_addr = a;
        exp_q.push_back(a[7] ? rx_m[fold(a)] : tx_m[fold(a)]);
        tag_q.push_back(tag);
    endtask

    task automatic bus_read(logic [7:0] a, string tag);
        push_read(a, tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic eng_tx(int idx, string tag);
        eng_tx_idx = IDXW'(idx);
        @(negedge clk);
        check(tag, eng_tx_word, tx_m[idx]);
        check(tag, {28'd0, eng_tx_par}, {28'd0, par4(tx_m[idx])});
    endtask

    task automatic start_rx(int idx, logic [7:0] fl, logic [15:0] d);
        eng_rx_we = 1'b1; eng_rx_idx = IDXW'(idx); eng_rx_flags = fl; eng_rx_data = d;
        rx_m[idx] = {fl, tx_m[idx][23:16], d};
    endtask

    // monitor: pops one expected item per captured read
    always @(posedge clk) issued <= rst_n && bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (issued && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, bus_rdata, e);
            check({t, " parity"}, {28'd0, bus_rpar}, {28'd0, par4(e)});
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin tx_m[i] = '0; rx_m[i] = '0; end
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_word_addr = '0; bus_be = '0;
        bus_wdata = '0; eng_tx_idx = '0; eng_rx_we = 1'b0; eng_rx_idx = '0;
        eng_rx_data = '0; eng_rx_flags = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", bus_rdata, 32'd0);
        check("R1 txword", eng_tx_word, 32'd0);
        bus_read(8'h03, "R1 tx entry");
        bus_read(8'h85, "R1 rx entry");
        eng_tx(9, "R1 engine");

        // R2 word write/read, R4 parity
        bus_write(8'h02, 4'hF, 32'h12AB_5678);
        bus_read(8'h02, "R2 word");
        bus_write(8'h05, 4'hF, 32'hFFFF_0001);
        bus_read(8'h05, "R4 mixed parity");

        // R3 byte and halfword lanes
        bus_write(8'h02, 4'b0010, 32'h0000_EE00);
        bus_write(8'h02, 4'b1000, 32'h9C00_0000);
        bus_read(8'h02, "R3 byte lanes");
        bus_write(8'h04, 4'b1100, 32'hCAFE_0000);
        bus_write(8'h04, 4'b0001, 32'h1111_1177);
        bus_read(8'h04, "R3 half and byte");

        // R5 receive window ignores bus writes
        bus_write(8'h81, 4'hF, 32'hDEAD_BEEF);
        bus_read(8'h81, "R5 rx unchanged");
        bus_read(8'h01, "R5 tx unchanged");

        // R6 aliasing
        bus_write(8'd19, 4'hF, 32'h0BAD_F00D);
        bus_read(8'h03, "R6 alias write");
        bus_write(8'h0F, 4'hF, 32'h1357_9BDF);
        bus_read(8'd127, "R6 top alias");
        bus_read(8'd35, "R6 second alias");

        // R7 engine transmit read, plus same-cycle bus write
        eng_tx(2, "R7 idx2");
        eng_tx(4, "R7 idx4");
        eng_tx_idx = IDXW'(6);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word_addr = 8'h06; bus_be = 4'hF;
        bus_wdata = 32'h55AA_33CC;
        model_tx_write(8'h06, 4'hF, 32'h55AA_33CC);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R7 forwarded", eng_tx_word, 32'h55AA_33CC);

        // R8 receive write with chip-select copy
        start_rx(2, 8'hA5, 16'h1234);
        @(negedge clk);
        eng_rx_we = 1'b0;
        bus_read(8'h82, "R8 cs copy");
        check("R8 model", rx_m[2], 32'hA5AB_1234);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_word_addr = 8'h07; bus_be = 4'hF;
        bus_wdata = 32'h003C_0000;
        model_tx_write(8'h07, 4'hF, 32'h003C_0000);
        start_rx(7, 8'h11, 16'hBEEF);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; eng_rx_we = 1'b0;
        bus_read(8'h87, "R8 same-cycle cs");
        bus_read(8'h92, "R6 rx alias");

        // R9 read of receive entry during engine write returns old contents
        push_read(8'h82, "R9 old value");
        start_rx(2, 8'h5A, 16'h0F0F);
        @(negedge clk);
        bus_sel = 1'b0; eng_rx_we = 1'b0;
        bus_read(8'h82, "R9 new value");

        // R10 hold through idle and write cycles
        bus_word_addr = 8'h05;
        repeat (2) @(negedge clk);
        check("R10 idle hold", bus_rdata, 32'h5AAB_0F0F);
        bus_write(8'h85, 4'hF, 32'h0);
        bus_write(8'h05, 4'hF, 32'h7777_7777);
        check("R10 write hold", bus_rdata, 32'h5AAB_0F0F);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule